// File: doc/BRIEF.md
# Reconfigurable Two-Node Stage Switch

This switching element sits in one stage of a two-stage network and serves two locally attached nodes. The nodes program it themselves through a 20-bit control word. Nothing else controls it. The word holds a network shape selector: linear chain, binary tree or cube. It also holds one 9-bit slice per local node. A slice gives the node's direction (send or take) and the 4-bit numbers of the far-stage partners it sends to and takes from.

When a node asks for service and wins the switch, its stored partner number steers the data path directly, with no decode step in between:

- **Sending:** the node's word is placed on the outgoing inter-stage line, tagged with the partner number.
- **Taking:** the incoming line whose index equals the stored number is routed back to the node.

Only one transfer runs in the switch at any time.

In tree shape, a parent node collects from two children with the left one first. The switch keeps the parent's grant across both collections, so the other local node cannot cut in between them. The parent rewrites its take address between the two collections.

Top module: `sw_pair_switch`

## Requirements
- R1: A synchronous active-high reset clears all of the following: the control word `ctrl_q`, the grant, every valid output and every data and address output. After reset the switch is in linear shape and both nodes are idle in take direction.
- R2: The control word layout is as follows: `ctrl_q[19:18]` is the shape, `ctrl_q[17:9]` is the node 1 slice and `ctrl_q[8:0]` is the node 0 slice. Within a slice, bit 8 is the direction (1 = send, 0 = take), bits 7:4 are the send partner and bits 3:0 are the take partner. When `slice_we[i]` is high at a clock edge, slice i is loaded from `slice_wdata[9*i +: 9]`. The other slice and the shape field are left unchanged.
- R3: When `mode_we` is high at a clock edge, the shape field is loaded from `mode_wdata`, and both slices keep their values. The encodings are 0 = linear, 1 = tree, 2 = cube and 3 = reserved.
- R4: `grant` (bit i = node i) has at most one bit set. A request seen at an edge while the switch is idle sets the grant at that edge. When both nodes request at the same edge, node 0 wins.
- R5: A grant stays set until the owner raises `done` at an edge. The grant then clears at that edge, and any new grant can come no earlier than the following edge. The other node is held off until then.
- R6: When the owner's direction is send, the switch drives the following: `remote_tx_valid` = 1, `remote_tx_addr` equal to the owner's send partner field, and `remote_tx_data` equal to the owner's word on `loc_tx_data`. `loc_rx_valid` stays 0. Whenever `remote_tx_valid` is 0, the address and data outputs are 0.
- R7: When the owner's direction is take, the switch sets `loc_rx_valid` for the owner. It drives `loc_rx_data` with `remote_rx_data[8*a +: 8]`, where a is the owner's take partner field, and `remote_tx_valid` stays 0. Whenever `loc_rx_valid` is 0, `loc_rx_data` is 0.
- R8: In tree shape, a take-direction owner keeps its grant through its first `done`, which ends the left-child collection. It releases the grant only on its second `done`, which ends the right-child collection.
- R9: In tree shape, a send-direction owner (a leaf) releases on its first `done`. Its take partner field has no effect on any output.
- R10: While the shape field is 3 (reserved), `grant`, `remote_tx_valid` and `loc_rx_valid` are all 0. Requests are not granted, and any grant already held is dropped at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slice_we | input | 2 | Per-node slice write strobe |
| slice_wdata | input | 18 | Slice write data, node i at [9*i +: 9] |
| mode_we | input | 1 | Shape field write strobe |
| mode_wdata | input | 2 | Shape field write data |
| req | input | 2 | Per-node transfer request |
| done | input | 2 | Per-node end-of-transfer strobe |
| loc_tx_data | input | 16 | Words from the local nodes, node i at [8*i +: 8] |
| loc_rx_data | output | 8 | Word routed to the taking node |
| loc_rx_valid | output | 2 | Per-node take valid |
| remote_rx_data | input | 128 | Incoming words from the 16 far-stage lines |
| remote_tx_data | output | 8 | Outgoing word to the far stage |
| remote_tx_addr | output | 4 | Far-stage partner number of the outgoing word |
| remote_tx_valid | output | 1 | Outgoing word valid |
| grant | output | 2 | Current transfer owner, one-hot or zero |
| ctrl_q | output | 20 | Current control word |

## Verification
The bench aims at the following corner cases, and names the fault each one exposes:

- **Simultaneous requests.** A design that favoured node 1 would start the wrong transfer.
- **Early release of the grant.** This covers a grant dropped without `done`, and also a grant dropped at the first `done` of a tree-shape take. Either way, the other node would steal the switch in the middle of a tree collection.
- **Leaf that held on.** A tree-shape sender that kept its grant after `done` would stall both nodes.
- **Reserved shape.** A design that still granted, or kept a live grant while the shape was 3, would put words on the lines.
- **Steering.** These checks catch a take path that indexes the wrong line, a send that carries the take field as its address, and a slice write that disturbs the other slice or the shape field.

// File: rtl/sw_pair_pkg.sv
package sw_pair_pkg;

    localparam int NODES   = 2;
    localparam int ADDR_W  = 4;
    localparam int MODE_W  = 2;
    localparam int SLICE_W = 1 + 2 * ADDR_W;
    localparam int CTRL_W  = MODE_W + NODES * SLICE_W;
    localparam int NLINES  = 1 << ADDR_W;

    typedef enum logic [MODE_W-1:0] {
        SHAPE_LINEAR = 2'd0,
        SHAPE_TREE   = 2'd1,
        SHAPE_CUBE   = 2'd2,
        SHAPE_RSVD   = 2'd3
    } shape_e;

    typedef struct packed {
        logic              send;
        logic [ADDR_W-1:0] tx_peer;
        logic [ADDR_W-1:0] rx_peer;
    } slice_t;

    typedef struct packed {
        shape_e                  shape;
        slice_t [NODES-1:0]      slc;
    } ctrl_t;

    function automatic logic shape_live(shape_e s);
        return s != SHAPE_RSVD;
    endfunction

    function automatic logic needs_second_pass(shape_e s, slice_t sl);
        return (s == SHAPE_TREE) && !sl.send;
    endfunction

endpackage

// File: rtl/sw_cfg_reg.sv
module sw_cfg_reg
    import sw_pair_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NODES-1:0]       slice_we,
    input  slice_t [NODES-1:0]     slice_wdata,
    input  logic                   mode_we,
    input  shape_e                 mode_wdata,
    output ctrl_t                  ctrl
);

    always_ff @(posedge clk) begin
        if (rst)          ctrl.shape <= SHAPE_LINEAR;
        else if (mode_we) ctrl.shape <= mode_wdata;
    end

    for (genvar i = 0; i < NODES; i++) begin : g_slice
        always_ff @(posedge clk) begin
            if (rst)              ctrl.slc[i] <= '0;
            else if (slice_we[i]) ctrl.slc[i] <= slice_wdata[i];
        end
    end

endmodule

// File: rtl/sw_arbiter.sv
module sw_arbiter
    import sw_pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NODES-1:0] req,
    input  logic [NODES-1:0] done,
    input  ctrl_t            ctrl,
    output logic [NODES-1:0] grant
);

    logic [NODES-1:0] grant_q;
    logic             second_q;
    logic             owner;
    logic             live;

    always_comb begin
        owner = grant_q[1];
        live  = shape_live(ctrl.shape);
        grant = live ? grant_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !live) begin
            grant_q  <= '0;
            second_q <= 1'b0;
        end else if (grant_q == '0) begin
            second_q <= 1'b0;
            if (req[0])      grant_q <= 2'b01;
            else if (req[1]) grant_q <= 2'b10;
        end else if (done[owner]) begin
            if (needs_second_pass(ctrl.shape, ctrl.slc[owner]) && !second_q) begin
                second_q <= 1'b1;
            end else begin
                grant_q  <= '0;
                second_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sw_steer.sv
module sw_steer
    import sw_pair_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  ctrl_t                      ctrl,
    input  logic [NODES-1:0]           grant,
    input  logic [NODES*DATA_W-1:0]    loc_tx_data,
    input  logic [NLINES*DATA_W-1:0]   remote_rx_data,
    output logic [DATA_W-1:0]          loc_rx_data,
    output logic [NODES-1:0]           loc_rx_valid,
    output logic [DATA_W-1:0]          remote_tx_data,
    output logic [ADDR_W-1:0]          remote_tx_addr,
    output logic                       remote_tx_valid
);

    logic   owner;
    slice_t osl;

    always_comb begin
        owner           = grant[1];
        osl             = ctrl.slc[owner];
        loc_rx_data     = '0;
        loc_rx_valid    = '0;
        remote_tx_data  = '0;
        remote_tx_addr  = '0;
        remote_tx_valid = 1'b0;
        if (grant != '0) begin
            if (osl.send) begin
                remote_tx_valid = 1'b1;
                remote_tx_addr  = osl.tx_peer;
                remote_tx_data  = loc_tx_data[int'(owner)*DATA_W +: DATA_W];
            end else begin
                loc_rx_valid[owner] = 1'b1;
                loc_rx_data = remote_rx_data[int'(osl.rx_peer)*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/sw_pair_switch.sv
module sw_pair_switch
    import sw_pair_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NODES-1:0]           slice_we,
    input  logic [NODES*SLICE_W-1:0]   slice_wdata,
    input  logic                       mode_we,
    input  logic [MODE_W-1:0]          mode_wdata,
    input  logic [NODES-1:0]           req,
    input  logic [NODES-1:0]           done,
    input  logic [NODES*DATA_W-1:0]    loc_tx_data,
    output logic [DATA_W-1:0]          loc_rx_data,
    output logic [NODES-1:0]           loc_rx_valid,
    input  logic [NLINES*DATA_W-1:0]   remote_rx_data,
    output logic [DATA_W-1:0]          remote_tx_data,
    output logic [ADDR_W-1:0]          remote_tx_addr,
    output logic                       remote_tx_valid,
    output logic [NODES-1:0]           grant,
    output logic [CTRL_W-1:0]          ctrl_q
);

    ctrl_t              ctrl;
    slice_t [NODES-1:0] wslices;

    assign wslices = slice_wdata;
    assign ctrl_q  = ctrl;

    sw_cfg_reg u_cfg (
        .clk         (clk),
        .rst         (rst),
        .slice_we    (slice_we),
        .slice_wdata (wslices),
        .mode_we     (mode_we),
        .mode_wdata  (shape_e'(mode_wdata)),
        .ctrl        (ctrl)
    );

    sw_arbiter u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .done  (done),
        .ctrl  (ctrl),
        .grant (grant)
    );

    sw_steer #(.DATA_W(DATA_W)) u_steer (
        .ctrl            (ctrl),
        .grant           (grant),
        .loc_tx_data     (loc_tx_data),
        .remote_rx_data  (remote_rx_data),
        .loc_rx_data     (loc_rx_data),
        .loc_rx_valid    (loc_rx_valid),
        .remote_tx_data  (remote_tx_data),
        .remote_tx_addr  (remote_tx_addr),
        .remote_tx_valid (remote_tx_valid)
    );

endmodule

// File: rtl/sw_pair_switch_chk.sv
module sw_pair_switch_chk (
    input logic        clk,
    input logic        rst,
    input logic        mode_we,
    input logic [1:0]  mode_wdata,
    input logic [1:0]  done,
    input logic [1:0]  grant,
    input logic        remote_tx_valid,
    input logic [3:0]  remote_tx_addr,
    input logic [1:0]  loc_rx_valid,
    input logic [19:0] ctrl_q
);

    logic going_rsvd;
    assign going_rsvd = mode_we && (mode_wdata == 2'd3);

    // R1: state is cleared after a reset edge
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (ctrl_q == 20'd0 && grant == 2'b00));

    // R4: never two owners
    p_single_owner_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5: node 0 keeps its grant until it signals done
    p_hold0_r5: assert property (@(posedge clk) disable iff (rst)
        (grant[0] && !done[0] && !going_rsvd) |=> grant[0]);

    // R5: node 1 keeps its grant until it signals done
    p_hold1_r5: assert property (@(posedge clk) disable iff (rst)
        (grant[1] && !done[1] && !going_rsvd) |=> grant[1]);

    // R6: outgoing address is the owner's stored send partner
    p_tx_addr_r6: assert property (@(posedge clk) disable iff (rst)
        remote_tx_valid |-> (grant[0] ? remote_tx_addr == ctrl_q[7:4]
                                      : remote_tx_addr == ctrl_q[16:13]));

    // R7: send and take are never both active
    p_dir_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(remote_tx_valid && (loc_rx_valid != 2'b00)));

    // R10: reserved shape moves nothing
    p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[19:18] == 2'd3) |-> (grant == 2'b00 && !remote_tx_valid && loc_rx_valid == 2'b00));

endmodule

bind sw_pair_switch sw_pair_switch_chk u_chk (.*);

// File: tb/sim_sw_pair_switch.sv
module sim_sw_pair_switch;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  slice_we;
    logic [17:0] slice_wdata;
    logic        mode_we;
    logic [1:0]  mode_wdata;
    logic [1:0]  req;
    logic [1:0]  done;
    logic [15:0] loc_tx_data;
    logic [7:0]  loc_rx_data;
    logic [1:0]  loc_rx_valid;
    logic [127:0] remote_rx_data;
    logic [7:0]  remote_tx_data;
    logic [3:0]  remote_tx_addr;
    logic        remote_tx_valid;
    logic [1:0]  grant;
    logic [19:0] ctrl_q;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [1:0] m_mode;
    logic [8:0] m_slc [2];
    logic [1:0] m_g;
    logic       m_ph;

    always #(CLK_PERIOD/2) clk = ~clk;

    sw_pair_switch #(.DATA_W(DW)) u0 (.*);

    task automatic chk(input bit ok, input string ctx, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", ctx, what, act, exp);
        end
    endtask

    task automatic check_outputs(input string ctx);
        logic [1:0] eg; logic etv; logic [3:0] eta; logic [7:0] etd;
        logic [1:0] erv; logic [7:0] erd; logic o;
        eg = (m_mode != 2'd3) ? m_g : 2'b00;
        etv = 0; eta = 0; etd = 0; erv = 0; erd = 0;
        if (eg != 2'b00) begin
            o = eg[1];
            if (m_slc[o][8]) begin
                etv = 1; eta = m_slc[o][7:4]; etd = loc_tx_data[int'(o)*8 +: 8];
            end else begin
                erv[o] = 1'b1; erd = remote_rx_data[int'(m_slc[o][3:0])*8 +: 8];
            end
        end
        chk(ctrl_q == {m_mode, m_slc[1], m_slc[0]}, ctx, "R2 R3 ctrl_q",
            32'(ctrl_q), 32'({m_mode, m_slc[1], m_slc[0]}));
        chk(grant == eg, ctx, "R4 R5 grant", 32'(grant), 32'(eg));
        chk({remote_tx_valid, remote_tx_addr, remote_tx_data} == {etv, eta, etd}, ctx,
            "R6 send path", 32'({remote_tx_valid, remote_tx_addr, remote_tx_data}),
            32'({etv, eta, etd}));
        chk({loc_rx_valid, loc_rx_data} == {erv, erd}, ctx, "R7 take path",
            32'({loc_rx_valid, loc_rx_data}), 32'({erv, erd}));
    endtask

    task automatic model_edge();
        logic o;
        if (rst) begin
            m_mode = 0; m_slc[0] = 0; m_slc[1] = 0; m_g = 0; m_ph = 0;
            return;
        end
        if (m_mode == 2'd3) begin
            m_g = 0; m_ph = 0;
        end else if (m_g == 2'b00) begin
            m_ph = 0;
            if (req[0]) m_g = 2'b01;
            else if (req[1]) m_g = 2'b10;
        end else begin
            o = m_g[1];
            if (done[o]) begin
                if (m_mode == 2'd1 && !m_slc[o][8] && !m_ph) m_ph = 1;
                else begin m_g = 0; m_ph = 0; end
            end
        end
        if (mode_we) m_mode = mode_wdata;
        for (int i = 0; i < 2; i++) if (slice_we[i]) m_slc[i] = slice_wdata[9*i +: 9];
    endtask

    task automatic cyc(input string ctx);
        #1;
        check_outputs(ctx);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        slice_we = 0; mode_we = 0; req = 0; done = 0; rst = 0;
    endtask

    task automatic wr_slice(input int n, input logic s, input logic [3:0] tx, input logic [3:0] rx);
        slice_we[n] = 1'b1;
        slice_wdata[9*n +: 9] = {s, tx, rx};
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        idle();
        slice_wdata = 0; mode_wdata = 0; loc_tx_data = 16'hB4A5;
        for (int i = 0; i < 16; i++) remote_rx_data[i*8 +: 8] = 8'(8'h30 + i);
        m_mode = 0; m_slc[0] = 0; m_slc[1] = 0; m_g = 0; m_ph = 0;
        @(negedge clk);
        rst = 1; req = 2'b11;
        @(posedge clk); model_edge(); @(negedge clk);
        @(posedge clk); model_edge(); @(negedge clk);
        idle(); req = 2'b00;
        cyc("R1 after reset");

        // R2 R3: write each field alone
        wr_slice(0, 1, 4'd5, 4'd3); cyc("R2 slice0 write");
        idle(); wr_slice(1, 0, 4'd9, 4'd6); cyc("R2 slice1 write");
        idle(); mode_we = 1; mode_wdata = 2'd2; cyc("R3 cube write");
        idle(); cyc("R3 hold");

        // R4: both request, node 0 first; R6 send from node 0
        req = 2'b11; cyc("R4 both request");
        cyc("R6 node0 sending");
        req = 2'b10; done = 2'b01; cyc("R5 node0 done");
        done = 2'b00; cyc("R4 node1 granted next");
        cyc("R7 node1 taking line 6");
        done = 2'b10; req = 0; cyc("R5 node1 done");
        idle(); cyc("R5 idle");

        // R8: tree take, two collections
        mode_we = 1; mode_wdata = 2'd1; wr_slice(0, 0, 4'd0, 4'd2); cyc("R8 setup");
        idle(); req = 2'b01; cyc("R8 request");
        req = 2'b10; cyc("R8 left child");
        done = 2'b01; cyc("R8 first done");
        done = 0; wr_slice(0, 0, 4'd0, 4'd11); cyc("R8 grant held after first done");
        idle(); req = 2'b10; cyc("R8 right child");
        done = 2'b01; cyc("R8 second done");
        idle(); cyc("R8 released");

        // R9: tree leaf sender, rx field ignored
        wr_slice(1, 1, 4'd14, 4'd7); cyc("R9 setup");
        idle(); req = 2'b10; cyc("R9 request");
        req = 0; wr_slice(1, 1, 4'd14, 4'd1); cyc("R9 rx field changed");
        idle(); done = 2'b10; cyc("R9 single done");
        idle(); cyc("R9 released");

        // R10: reserved shape
        req = 2'b01; cyc("R10 grant before");
        req = 0; mode_we = 1; mode_wdata = 2'd3; cyc("R10 go reserved");
        idle(); req = 2'b11; cyc("R10 no grant");
        cyc("R10 still none");
        req = 0; mode_we = 1; mode_wdata = 2'd0; cyc("R10 leave");
        idle(); cyc("R10 idle");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            idle();
            loc_tx_data = 16'($urandom);
            for (int i = 0; i < 16; i++) remote_rx_data[i*8 +: 8] = 8'($urandom);
            if ($urandom_range(0, 9) == 0) begin
                slice_we = 2'($urandom);
                slice_wdata = 18'($urandom);
            end
            if ($urandom_range(0, 19) == 0) begin
                mode_we = 1;
                mode_wdata = ($urandom_range(0, 7) == 0) ? 2'd3 : 2'($urandom_range(0, 2));
            end
            req  = 2'($urandom);
            done = ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00;
            if ($urandom_range(0, 499) == 0) rst = 1;
            cyc("R4 R5 R8 random");
        end

        summary();
        $finish;
    end

endmodule